// File: doc/BRIEF.md
# Serial Port Bit Clock Generator

This block produces the bit clock of a synchronous serial port from the peripheral clock. It divides in two cascaded stages. The first stage is an even-only prescaler. The second stage divides the prescaled rate by one plus an 8-bit rate field. The two ratios multiply, so one full serial clock period lasts `P * (rate + 1)` peripheral clock cycles, where `P` is the effective prescale.

In master mode the block drives a 50% duty serial clock. It also gives single-cycle pulses that mark each rising and each falling transition. In slave mode the serial clock stays at its idle low level. The prescaler keeps running in slave mode, and its strobe, one pulse per prescale period, is still produced for the receive sampling logic. Configuration changes are picked up only at a period boundary, so a period in progress is never cut short.

Top module: `bitclk_gen`

## Requirements
- R1: The effective prescale P is `preDiv` with bit 0 forced to 0, and any result below 2 is raised to 2, so P is even and lies in 2..254. While enabled, `sampleStrobe` pulses for one cycle once every P cycles. The first pulse comes P cycles after enable rises.
- R2: In master mode one `sclkOut` period lasts P*(rateSel+1) cycles. The clock is high for exactly half of that and low for the other half.
- R3: `riseTick` is high for exactly one cycle, in the first cycle that `sclkOut` is high. `fallTick` is high for exactly one cycle, in the first cycle that `sclkOut` is low again. The two are never high together.
- R4: In slave mode `sclkOut` stays low and neither tick is issued. `sampleStrobe` keeps pulsing every P cycles.
- R5: While `enable` is low, all counters are held at zero. From the first clock edge at which `enable` is low, `sclkOut`, `riseTick`, `fallTick` and `sampleStrobe` are all low. A later enable starts counting from zero.
- R6: While enabled, new `preDiv`, `rateSel` and `isMaster` values take effect only at a period boundary. In master mode the boundary is the end of a serial clock period, which is its falling transition. In slave mode the boundary is the end of a prescale period. While disabled, the inputs are taken on every cycle.
- R7: Timing after enable: with M = rateSel+1, the first rising transition comes M*P/2 cycles after enable rises, and the first falling transition comes M*P cycles after it.
- R8: The extreme ratios work. P=2 with rateSel=0 gives a 2-cycle period. P=2 with rateSel=255 gives a 512-cycle period. P=254 with rateSel=255 gives a 65024-cycle period.
- R9: After reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the dividers when high; clears them when low |
| isMaster | input | 1 | 1 = master (drive serial clock), 0 = slave |
| preDiv | input | 8 | Prescale setting; bit 0 ignored, minimum 2 |
| rateSel | input | 8 | Second-stage setting; divides by rateSel+1 |
| sclkOut | output | 1 | Serial bit clock, idle low |
| riseTick | output | 1 | One-cycle pulse with each rising serial clock transition |
| fallTick | output | 1 | One-cycle pulse with each falling serial clock transition |
| sampleStrobe | output | 1 | One-cycle pulse at the end of each prescale period |

## Verification
Master runs use several prescale and rate pairs: the fastest 2-cycle period, odd and sub-2 prescale settings that exercise the bit-0 and clamp rules, the largest prescale, and the largest rate. Together these separate a product of the two stages from a sum, and show whether the half-period split is exact. Runs that change the settings in mid-period, in either mode and across a mode switch, show whether the new values wait for the boundary or cut the current period short. Slave runs and a disable in mid-period confirm that the serial clock stays quiet while the prescaler strobe continues, and that a later enable restarts from zero.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } clkMode_e;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic clrAll;     // enable low: zero everything
    logic loadCfg;    // capture new settings
    logic wrapPre;    // prescale counter returns to zero
    logic incRate;    // advance second-stage counter
    logic wrapRate;   // second-stage counter returns to zero
    logic toggleClk;  // invert serial clock
    logic sampleHit;  // end of a prescale period
  } ctlStrobe_t;

  // compare results returned by the datapath
  typedef struct packed {
    logic preHalf;
    logic preLast;
    logic rateLast;
    logic sclkHigh;
  } dpFlags_t;

endpackage

// File: rtl/bitclk_dp.sv
module bitclk_dp
  import bitclk_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  preDiv,
  input  logic [RATE_W-1:0] rateSel,
  input  ctlStrobe_t        ctl,
  output dpFlags_t          flags,
  output logic              sclkOut,
  output logic              riseTick,
  output logic              fallTick,
  output logic              sampleStrobe
);

  localparam int HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] halfReq;
  logic [HALF_W-1:0] halfEff;
  logic [HALF_W-1:0] halfPre;
  logic [RATE_W-1:0] rateMax;
  logic [PRE_W-1:0]  preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic [PRE_W-1:0]  halfTop;
  logic [PRE_W-1:0]  fullTop;
  logic              sclkR;
  logic              riseR;
  logic              fallR;
  logic              sampR;

  // even-only prescale: drop bit 0, clamp to at least 2
  assign halfReq = preDiv[PRE_W-1:1];
  assign halfEff = (halfReq == '0) ? HALF_W'(1) : halfReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfPre <= HALF_W'(1);
      rateMax <= '0;
    end else if (ctl.loadCfg) begin
      halfPre <= halfEff;
      rateMax <= rateSel;
    end
  end

  assign halfTop = {1'b0, halfPre} - PRE_W'(1);
  assign fullTop = {halfPre, 1'b0} - PRE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctl.clrAll || ctl.wrapPre) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCnt <= '0;
    end else if (ctl.clrAll || ctl.wrapRate) begin
      rateCnt <= '0;
    end else if (ctl.incRate) begin
      rateCnt <= rateCnt + RATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkR <= 1'b0;
      riseR <= 1'b0;
      fallR <= 1'b0;
      sampR <= 1'b0;
    end else begin
      if (ctl.clrAll) begin
        sclkR <= 1'b0;
      end else if (ctl.toggleClk) begin
        sclkR <= ~sclkR;
      end
      riseR <= !ctl.clrAll && ctl.toggleClk && !sclkR;
      fallR <= !ctl.clrAll && ctl.toggleClk && sclkR;
      sampR <= !ctl.clrAll && ctl.sampleHit;
    end
  end

  assign flags.preHalf  = (preCnt == halfTop);
  assign flags.preLast  = (preCnt == fullTop);
  assign flags.rateLast = (rateCnt == rateMax);
  assign flags.sclkHigh = sclkR;

  assign sclkOut      = sclkR;
  assign riseTick     = riseR;
  assign fallTick     = fallR;
  assign sampleStrobe = sampR;

  // R3: rise pulse sits in the first high cycle
  assert_rise_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    riseR |-> (sclkR && !$past(sclkR)));

  // R3: fall pulse sits in the first low cycle
  assert_fall_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    fallR |-> (!sclkR && $past(sclkR)));

  assert_tick_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(riseR && fallR));

  // R5: one edge with enable low leaves everything cleared
  assert_clear_on_disable_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clrAll) |-> (!sclkR && !riseR && !fallR && !sampR && preCnt == '0 && rateCnt == '0));

  // R1: stored half-prescale never reaches zero
  assert_half_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    halfPre != '0);

  // R2: counters stay inside the programmed ranges
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt <= fullTop) && (rateCnt <= rateMax));

endmodule

// File: rtl/bitclk_ctrl.sv
module bitclk_ctrl
  import bitclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       isMaster,
  input  dpFlags_t   flags,
  output ctlStrobe_t ctl
);

  clkMode_e modeR;
  logic     halfHit;
  logic     boundary;
  logic     masterOn;

  assign masterOn = (modeR == MODE_MASTER);
  assign halfHit  = enable && (flags.preHalf || flags.preLast);

  always_comb begin
    ctl           = '0;
    ctl.clrAll    = !enable;
    ctl.wrapPre   = enable && flags.preLast;
    ctl.sampleHit = enable && flags.preLast;
    ctl.incRate   = masterOn && halfHit && !flags.rateLast;
    ctl.wrapRate  = masterOn && halfHit && flags.rateLast;
    ctl.toggleClk = masterOn && halfHit && flags.rateLast;
    boundary      = masterOn ? (ctl.wrapRate && flags.sclkHigh) : ctl.wrapPre;
    ctl.loadCfg   = !enable || boundary;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= MODE_SLAVE;
    end else if (ctl.loadCfg) begin
      modeR <= isMaster ? MODE_MASTER : MODE_SLAVE;
    end
  end

  // R6: a master period boundary always coincides with a prescale wrap
  assert_boundary_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && masterOn && ctl.wrapRate && flags.sclkHigh) |-> flags.preLast);

  // R4: slave mode never toggles the serial clock
  assert_slave_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeR == MODE_SLAVE) |-> !ctl.toggleClk);

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              isMaster,
  input  logic [PRE_W-1:0]  preDiv,
  input  logic [RATE_W-1:0] rateSel,
  output logic              sclkOut,
  output logic              riseTick,
  output logic              fallTick,
  output logic              sampleStrobe
);

  ctlStrobe_t ctl;
  dpFlags_t   flags;

  bitclk_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .isMaster (isMaster),
    .flags    (flags),
    .ctl      (ctl)
  );

  bitclk_dp #(.PRE_W(PRE_W), .RATE_W(RATE_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .preDiv       (preDiv),
    .rateSel      (rateSel),
    .ctl          (ctl),
    .flags        (flags),
    .sclkOut      (sclkOut),
    .riseTick     (riseTick),
    .fallTick     (fallTick),
    .sampleStrobe (sampleStrobe)
  );

endmodule

// File: tb/bitclk_gen_test.sv
`timescale 1ns/100ps
module bitclk_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       isMaster = 1'b0;
  logic [7:0] preDiv = 8'd2;
  logic [7:0] rateSel = 8'd0;
  logic       sclkOut, riseTick, fallTick, sampleStrobe;

  int    q[$];
  int    k = 0;
  int    checks = 0;
  int    errors = 0;
  bit    expSclk = 1'b0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  bitclk_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .preDiv(preDiv), .rateSel(rateSel), .sclkOut(sclkOut),
    .riseTick(riseTick), .fallTick(fallTick), .sampleStrobe(sampleStrobe)
  );

  function automatic int effP(input logic [7:0] v);
    int p = int'(v & 8'hFE);
    return (p < 2) ? 2 : p;
  endfunction

  // expected events: cycle*4 + kind (0 sample, 1 rise, 2 fall)
  task automatic pushPeriod(input int s, input int p, input int m, input bit mst);
    if (mst) begin
      for (int i = 1; i <= m; i++) q.push_back((s + i * p) * 4);
      q.push_back((s + m * p / 2) * 4 + 1);
      q.push_back((s + m * p) * 4 + 2);
    end else begin
      q.push_back((s + p) * 4);
    end
  endtask

  // monitor: compares outputs against popped expectations each cycle
  always @(posedge clk) begin
    bit eR, eF, eS;
    #1;
    if (rstN && !done) begin
      if (!enable) begin
        k = 0;
        expSclk = 1'b0;
        checks++;
        if (sclkOut || riseTick || fallTick || sampleStrobe) begin
          errors++;
          $display("FAIL R5 idle outputs sclk=%0b rise=%0b fall=%0b samp=%0b expected all 0",
                   sclkOut, riseTick, fallTick, sampleStrobe);
        end
      end else begin
        k++;
        eR = 0; eF = 0; eS = 0;
        while (q.size() > 0 && q[0] / 4 == k) begin
          case (q.pop_front() % 4)
            0: eS = 1;
            1: eR = 1;
            default: eF = 1;
          endcase
        end
        if (eR) expSclk = 1'b1;
        if (eF) expSclk = 1'b0;
        checks++;
        if (riseTick !== eR || fallTick !== eF || sampleStrobe !== eS || sclkOut !== expSclk) begin
          errors++;
          $display("FAIL %s cycle %0d: sclk/rise/fall/samp=%0b%0b%0b%0b expected %0b%0b%0b%0b",
                   curReq, k, sclkOut, riseTick, fallTick, sampleStrobe,
                   expSclk, eR, eF, eS);
        end
      end
    end
  end

  // driver: config A for one period, optional switch to B mid-period
  task automatic runCase(input logic [7:0] preA, input logic [7:0] rateA, input bit mA,
                         input logic [7:0] preB, input logic [7:0] rateB, input bit mB,
                         input int nB, input int stopAt, input string req);
    int pA = effP(preA);
    int pB = effP(preB);
    int lenA = mA ? pA * (int'(rateA) + 1) : pA;
    int lenB = mB ? pB * (int'(rateB) + 1) : pB;
    int endCyc;
    int keep[$];
    curReq = req;
    @(negedge clk);
    preDiv = preA; rateSel = rateA; isMaster = mA;
    @(negedge clk);
    q.delete();
    pushPeriod(0, pA, int'(rateA) + 1, mA);
    for (int n = 0; n < nB; n++) pushPeriod(lenA + n * lenB, pB, int'(rateB) + 1, mB);
    q.sort();
    endCyc = lenA + nB * lenB;
    if (stopAt > 0) begin
      endCyc = stopAt;
      foreach (q[i]) if (q[i] / 4 <= stopAt) keep.push_back(q[i]);
      q = keep;
    end
    enable = 1'b1;
    for (int j = 1; j <= endCyc; j++) begin
      @(negedge clk);
      if (nB > 0 && j == lenA / 2) begin
        preDiv = preB; rateSel = rateB; isMaster = mB;
      end
    end
    enable = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected events never seen, expected 0", req, q.size());
      q.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs low straight out of reset
    checks++;
    if (sclkOut || riseTick || fallTick || sampleStrobe) begin
      errors++;
      $display("FAIL R9 in reset outputs=%0b%0b%0b%0b expected 0000",
               sclkOut, riseTick, fallTick, sampleStrobe);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (sclkOut || riseTick || fallTick || sampleStrobe) begin
      errors++;
      $display("FAIL R9 after reset outputs=%0b%0b%0b%0b expected 0000",
               sclkOut, riseTick, fallTick, sampleStrobe);
    end

    // R8 fastest: P=2, rate 0, three periods
    runCase(8'd2, 8'd0, 1, 8'd2, 8'd0, 1, 2, 0, "R8 R2 R3 R7");
    // R1 odd prescale 3 acts as 2
    runCase(8'd3, 8'd4, 1, 8'd3, 8'd4, 1, 1, 0, "R1 R2 R7");
    runCase(8'd6, 8'd2, 1, 8'd6, 8'd2, 1, 1, 0, "R2 R3 R7");
    // R1 clamp of 0 up to 2
    runCase(8'd0, 8'd1, 1, 8'd0, 8'd1, 1, 1, 0, "R1 R2");
    // largest prescale
    runCase(8'd255, 8'd0, 1, 8'd255, 8'd0, 1, 0, 0, "R1 R2");
    // R8 largest rate at smallest prescale
    runCase(8'd2, 8'd255, 1, 8'd2, 8'd255, 1, 0, 0, "R8 R2");
    // R6 master settings change mid-period
    runCase(8'd4, 8'd3, 1, 8'd8, 8'd1, 1, 2, 0, "R6 R2");
    runCase(8'd10, 8'd0, 1, 8'd2, 8'd2, 1, 1, 0, "R6 R3");
    // R4 slave: prescaler alone, serial clock quiet
    runCase(8'd10, 8'd7, 0, 8'd10, 8'd7, 0, 3, 0, "R4 R1");
    runCase(8'd6, 8'd0, 0, 8'd12, 8'd0, 0, 2, 0, "R4 R6");
    // R6 mode switch at a boundary, both directions
    runCase(8'd6, 8'd0, 0, 8'd4, 8'd1, 1, 2, 0, "R6 R4");
    runCase(8'd2, 8'd2, 1, 8'd4, 8'd0, 0, 2, 0, "R6 R4");
    // R5 disable in mid-period, then restart from zero
    runCase(8'd4, 8'd3, 1, 8'd4, 8'd3, 1, 0, 10, "R5");
    runCase(8'd4, 8'd1, 1, 8'd4, 8'd1, 1, 1, 0, "R5 R7");
    // R8 slowest ratio, one period
    runCase(8'd254, 8'd255, 1, 8'd254, 8'd255, 1, 0, 0, "R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", k);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule